// File: doc/BRIEF.md
# Buffered Configuration Port Transfer Engine

This peripheral sits on a simple word-wide host bus and owns a 512-word buffer memory. The host fills the buffer (or later drains it), programs a byte length and a starting word, then writes a direction word to launch a block move. In configuration direction the engine streams buffer words out on a 32-bit configuration port. In readback direction it requests words from that port and stores the returned words in the buffer.

The port side has a write strobe with data, a read request, returned data with a valid flag, and a busy input that throttles both directions. Four flag inputs from the port are folded into a status word together with the done bit. A write to the status address stops any running move and returns the engine to idle.

Bus reads return data one cycle after the read strobe. The buffer occupies byte addresses 0x000 to 0x7FF, and the registers sit at 0x800 and above.

Top module: `cfg_xfer_engine`

## Requirements
- R1: After reset, status bit 0 (done) reads 1, the length register (0x800) and the start-word register (0x804) read 0, and neither port strobe is active.
- R2: Buffer word N is written and read at byte address 4*N. Read data appears on bus_rdata with bus_rvalid high in the cycle after bus_rd.
- R3: The length register (0x800, bytes) and the start-word register (0x804) read back what was last written while idle. The direction register (0x808) reads 0.
- R4: Writing 0 to 0x808 sends size/4 words to the port in order, starting at buffer word offset, one port_wr pulse per word.
- R5: Writing 1 to 0x808 issues size/4 port_rd requests. The returned words (port_rvalid) are stored in order at consecutive buffer words starting at offset.
- R6: port_rd is never high in a cycle where port_busy is high. A port_wr pulse only follows a cycle in which port_busy was low.
- R7: Done reads 0 from the cycle after a launch with nonzero length. Done returns to 1 once the last word has been moved.
- R8: Status word layout: bit 0 done, bits 4..1 read as 1, bit 5 port_abort_n, bit 6 port_rip, bit 7 port_dalign, bit 8 port_cfgerr, higher bits 0.
- R9: Any write to the status address 0x80C, whatever its data, stops a running move. Done then reads 1 and no further port strobes occur.
- R10: A launch with length 0 produces no port strobes and done stays 1.
- R11: Writes to 0x800, 0x804 or 0x808 while a move is running have no effect on the register values or on the running move.
- R12: Byte address bits [1:0] are ignored on both reads and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Host byte address |
| bus_wr | input | 1 | Host write strobe |
| bus_wdata | input | 32 | Host write data |
| bus_rd | input | 1 | Host read strobe |
| bus_rdata | output | 32 | Host read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| port_wr | output | 1 | Configuration port write strobe |
| port_wdata | output | 32 | Configuration port write data |
| port_rd | output | 1 | Configuration port read request |
| port_rdata | input | 32 | Configuration port returned data |
| port_rvalid | input | 1 | Returned data valid |
| port_busy | input | 1 | Port cannot accept a transfer this cycle |
| port_abort_n | input | 1 | Active-low abort flag from the port |
| port_rip | input | 1 | Readback-in-progress flag from the port |
| port_dalign | input | 1 | Data-aligned flag from the port |
| port_cfgerr | input | 1 | Configuration-error flag from the port |

## Verification
Configuration moves run first with port_busy held low, which shows that order and count are right at full rate. A second move uses pseudo-random busy, which shows that throttling neither drops nor repeats a word. Readback runs with random busy and a two-cycle response delay, so request pacing is kept apart from where returned words land in the buffer. Busy is then held high during a move so that blocked register writes and a status-write abort can be seen at the registers and at the port. Zero-length launches in both directions cover the case where the start must leave the port untouched.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
  // Register select taken from byte address bits [3:2] in the register window
  typedef enum logic [1:0] {
    REG_LEN  = 2'd0,
    REG_BASE = 2'd1,
    REG_DIR  = 2'd2,
    REG_STAT = 2'd3
  } reg_sel_e;

  localparam int STAT_DONE_BIT  = 0;
  localparam int STAT_ABORT_BIT = 5;
  localparam int STAT_RIP_BIT   = 6;
  localparam int STAT_DALN_BIT  = 7;
  localparam int STAT_CERR_BIT  = 8;
endpackage

// File: rtl/cfgx_buffer.sv
module cfgx_buffer #(
  parameter int DEPTH  = 512,
  parameter int DATA_W = 32,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              a_we,
  input  logic [AW-1:0]     a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic              b_we,
  input  logic [AW-1:0]     b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  // Both write ports share one process; the host port wins a same-address clash
  always_ff @(posedge clk) begin
    if (b_we) mem[b_addr] <= b_wdata;
    if (a_we) mem[a_addr] <= a_wdata;
    a_rdata <= mem[a_addr];
    b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/cfgx_regs.sv
module cfgx_regs
  import cfgx_pkg::*;
#(
  parameter int DEPTH  = 512,
  parameter int DATA_W = 32,
  localparam int AW    = $clog2(DEPTH),
  localparam int BUS_AW = AW + 3,
  localparam int LEN_W = AW + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic              buf_we,
  output logic [AW-1:0]     buf_addr,
  input  logic [DATA_W-1:0] buf_rdata,
  input  logic              idle,
  input  logic              abort_n,
  input  logic              rip,
  input  logic              dalign,
  input  logic              cfgerr,
  output logic [LEN_W-1:0]  len_q,
  output logic [AW-1:0]     base_q,
  output logic              launch,
  output logic              launch_rb,
  output logic              abort
);
  logic     in_regs;
  reg_sel_e sel;
  logic     len_wr, base_wr;
  logic     rd_q, rd_reg_q;
  logic [DATA_W-1:0] reg_rd_q;

  assign in_regs  = bus_addr[BUS_AW-1];
  assign sel      = reg_sel_e'(bus_addr[3:2]);
  assign buf_addr = bus_addr[AW+1:2];
  assign buf_we   = bus_wr & ~in_regs;

  // Named decode events, used by the sequencer and by the assertions
  assign len_wr    = bus_wr & in_regs & (sel == REG_LEN);
  assign base_wr   = bus_wr & in_regs & (sel == REG_BASE);
  assign launch    = bus_wr & in_regs & (sel == REG_DIR) & idle;
  assign launch_rb = bus_wdata[0];
  assign abort     = bus_wr & in_regs & (sel == REG_STAT);

  function automatic logic [DATA_W-1:0] status_word(logic d, logic an, logic r,
                                                    logic da, logic ce);
    logic [DATA_W-1:0] w;
    w = '0;
    w[STAT_DONE_BIT]  = d;
    w[4:1]            = 4'hF;
    w[STAT_ABORT_BIT] = an;
    w[STAT_RIP_BIT]   = r;
    w[STAT_DALN_BIT]  = da;
    w[STAT_CERR_BIT]  = ce;
    return w;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= '0;
      base_q <= '0;
    end else begin
      if (len_wr && idle)  len_q  <= bus_wdata[LEN_W-1:0];
      if (base_wr && idle) base_q <= bus_wdata[AW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q     <= 1'b0;
      rd_reg_q <= 1'b0;
      reg_rd_q <= '0;
    end else begin
      rd_q     <= bus_rd;
      rd_reg_q <= bus_rd & in_regs;
      if (bus_rd && in_regs) begin
        unique case (sel)
          REG_LEN:  reg_rd_q <= DATA_W'(len_q);
          REG_BASE: reg_rd_q <= DATA_W'(base_q);
          REG_DIR:  reg_rd_q <= '0;
          REG_STAT: reg_rd_q <= status_word(idle, abort_n, rip, dalign, cfgerr);
          default:  reg_rd_q <= '0;
        endcase
      end
    end
  end

  assign bus_rdata  = rd_reg_q ? reg_rd_q : buf_rdata;
  assign bus_rvalid = rd_q;

  AST_LEN_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (len_wr && !idle) |=> $stable(len_q)); // R11
  AST_BASE_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (base_wr && !idle) |=> $stable(base_q)); // R11
endmodule

// File: rtl/cfgx_seq.sv
module cfgx_seq #(
  parameter int DEPTH  = 512,
  parameter int DATA_W = 32,
  localparam int AW    = $clog2(DEPTH),
  localparam int LEN_W = AW + 3,
  localparam int CNT_W = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort,
  input  logic              launch,
  input  logic              launch_rb,
  input  logic [LEN_W-1:0]  len_bytes,
  input  logic [AW-1:0]     base_in,
  input  logic              port_busy,
  output logic              port_wr,
  output logic [DATA_W-1:0] port_wdata,
  output logic              port_rd,
  input  logic [DATA_W-1:0] port_rdata,
  input  logic              port_rvalid,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              idle
);
  logic             running, dir_rb, wr_q;
  logic [CNT_W-1:0] words, issued, moved, launch_words;
  logic [AW-1:0]    base;
  logic             cfg_issue, rb_take, word_moved, last_move;

  function automatic logic [CNT_W-1:0] words_of(logic [LEN_W-1:0] nbytes);
    return nbytes[LEN_W-1:2];
  endfunction

  function automatic logic [AW-1:0] slot(logic [AW-1:0] b, logic [CNT_W-1:0] n);
    return b + n[AW-1:0];
  endfunction

  assign launch_words = words_of(len_bytes);
  assign cfg_issue  = running & ~dir_rb & ~port_busy & (issued < words);
  assign port_rd    = running &  dir_rb & ~port_busy & (issued < words);
  assign rb_take    = running &  dir_rb & port_rvalid & (moved < words);
  assign word_moved = wr_q | rb_take;
  assign last_move  = word_moved & (moved == words - 1'b1);

  assign mem_we     = rb_take;
  assign mem_wdata  = port_rdata;
  assign mem_addr   = dir_rb ? slot(base, moved) : slot(base, issued);
  assign port_wr    = wr_q;
  assign port_wdata = mem_rdata;
  assign idle       = ~running;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      dir_rb  <= 1'b0;
      wr_q    <= 1'b0;
      words   <= '0;
      issued  <= '0;
      moved   <= '0;
      base    <= '0;
    end else if (abort) begin
      running <= 1'b0;
      wr_q    <= 1'b0;
      issued  <= '0;
      moved   <= '0;
    end else begin
      wr_q <= cfg_issue;
      if (launch) begin
        running <= (launch_words != '0);
        dir_rb  <= launch_rb;
        words   <= launch_words;
        base    <= base_in;
        issued  <= '0;
        moved   <= '0;
      end else begin
        if (cfg_issue || port_rd) issued <= issued + 1'b1;
        if (word_moved)           moved  <= moved + 1'b1;
        if (last_move)            running <= 1'b0;
      end
    end
  end

  AST_LAUNCH_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && !abort && launch_words != '0) |=> !idle); // R7
  AST_ZERO_LEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && launch_words == '0) |=> (idle && !port_wr)); // R10
  AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (idle && !port_wr && !port_rd)); // R9
  AST_WR_AFTER_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    port_wr |-> $past(!port_busy)); // R6
  AST_MOVED_TRAILS_ISSUED: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !dir_rb) |-> (moved <= issued && issued <= words)); // R4
endmodule

// File: rtl/cfg_xfer_engine.sv
module cfg_xfer_engine #(
  parameter int DEPTH  = 512,
  parameter int DATA_W = 32,
  localparam int AW    = $clog2(DEPTH),
  localparam int BUS_AW = AW + 3,
  localparam int LEN_W = AW + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic              port_wr,
  output logic [DATA_W-1:0] port_wdata,
  output logic              port_rd,
  input  logic [DATA_W-1:0] port_rdata,
  input  logic              port_rvalid,
  input  logic              port_busy,
  input  logic              port_abort_n,
  input  logic              port_rip,
  input  logic              port_dalign,
  input  logic              port_cfgerr
);
  logic              buf_we, mem_we, idle, launch, launch_rb, abort;
  logic [AW-1:0]     buf_addr, mem_addr, base_q;
  logic [DATA_W-1:0] buf_rdata, mem_wdata, mem_rdata;
  logic [LEN_W-1:0]  len_q;

  cfgx_regs #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .buf_we(buf_we), .buf_addr(buf_addr),
    .buf_rdata(buf_rdata), .idle(idle), .abort_n(port_abort_n),
    .rip(port_rip), .dalign(port_dalign), .cfgerr(port_cfgerr),
    .len_q(len_q), .base_q(base_q), .launch(launch),
    .launch_rb(launch_rb), .abort(abort)
  );

  cfgx_buffer #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_buf (
    .clk(clk), .a_we(buf_we), .a_addr(buf_addr), .a_wdata(bus_wdata),
    .a_rdata(buf_rdata), .b_we(mem_we), .b_addr(mem_addr),
    .b_wdata(mem_wdata), .b_rdata(mem_rdata)
  );

  cfgx_seq #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .abort(abort), .launch(launch),
    .launch_rb(launch_rb), .len_bytes(len_q), .base_in(base_q),
    .port_busy(port_busy), .port_wr(port_wr), .port_wdata(port_wdata),
    .port_rd(port_rd), .port_rdata(port_rdata), .port_rvalid(port_rvalid),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .idle(idle)
  );
endmodule

// File: tb/cfg_xfer_engine_tb.sv
module cfg_xfer_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, port_wdata;
  logic        bus_rvalid, port_wr, port_rd;
  logic [31:0] port_rdata = '0;
  logic        port_rvalid = 1'b0, port_busy = 1'b0;
  logic        port_abort_n = 1'b1, port_rip = 1'b0, port_dalign = 1'b0, port_cfgerr = 1'b0;

  int checks = 0, failures = 0;
  logic [31:0] exp_q[$];
  logic [31:0] model [512];
  int  wr_seen = 0, rb_idx = 0, strays = 0;
  bit  allow_port = 1'b1, busy_force = 1'b0, busy_rand = 1'b0, rd_d = 1'b0, busy_prev = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  cfg_xfer_engine u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .port_wr(port_wr), .port_wdata(port_wdata),
    .port_rd(port_rd), .port_rdata(port_rdata), .port_rvalid(port_rvalid),
    .port_busy(port_busy), .port_abort_n(port_abort_n), .port_rip(port_rip),
    .port_dalign(port_dalign), .port_cfgerr(port_cfgerr)
  );

  always #5 clk = ~clk;

  function automatic logic [31:0] rb_pat(int i);
    return 32'hC3000000 ^ (i * 32'h00010203) ^ 32'h5A;
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Busy generator: changes just after each rising edge
  always @(posedge clk) begin
    #2;
    if (busy_force) port_busy = 1'b1;
    else if (busy_rand) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      port_busy = lfsr[0] & lfsr[3];
    end else port_busy = 1'b0;
  end

  // Port model and scoreboard monitor, sampled at the falling edge
  always @(negedge clk) begin
    if (port_wr) begin
      wr_seen++;
      if (exp_q.size() == 0) check(1'b0, "R4 unexpected port write", port_wdata, 32'h0);
      else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        check(port_wdata == e, "R4 port write data", port_wdata, e);
      end
      if (busy_prev) check(1'b0, "R6 write after busy cycle", 32'd1, 32'd0);
    end
    if (port_rd && port_busy) check(1'b0, "R6 read request while busy", 32'd1, 32'd0);
    if (!allow_port && (port_wr || port_rd)) strays++;
    if (port_rvalid) rb_idx++;
    port_rvalid = rd_d;
    port_rdata  = rb_pat(rb_idx);
    rd_d        = port_rd;
    busy_prev   = port_busy;
  end

  task automatic bus_write(logic [11:0] a, logic [31:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [11:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); #1;
    bus_rd = 1'b0;
    d = bus_rdata;
    check(bus_rvalid == 1'b1, "R2 read valid one cycle after strobe", {31'd0, bus_rvalid}, 32'd1);
  endtask

  task automatic wait_done();
    logic [31:0] s;
    s = '0;
    for (int i = 0; i < 3000; i++) begin
      bus_read(12'h80C, s);
      if (s[0]) break;
    end
    check(s[0] == 1'b1, "R7 done returns to 1", s, 32'h1);
  endtask

  // Driver: pushes the expected port stream, then launches a configuration move
  task automatic run_config(int offs, int n);
    for (int i = 0; i < n; i++) exp_q.push_back(model[offs + i]);
    bus_write(12'h800, 32'(n * 4));
    bus_write(12'h804, 32'(offs));
    bus_write(12'h808, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int w0, b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 / R8: reset state
    bus_read(12'h80C, r); check(r == 32'h3F, "R1 R8 status after reset", r, 32'h3F);
    bus_read(12'h800, r); check(r == 32'h0, "R1 length after reset", r, 32'h0);
    bus_read(12'h804, r); check(r == 32'h0, "R1 start word after reset", r, 32'h0);
    check(!port_wr && !port_rd, "R1 port idle after reset", {30'd0, port_wr, port_rd}, 32'h0);

    // R2: fill buffer words 0..127
    for (int i = 0; i < 128; i++) begin
      model[i] = 32'h1000_0000 + i * 32'h0011_0101;
      bus_write(12'(i * 4), model[i]);
    end
    bus_read(12'h014, r); check(r == model[5], "R2 buffer word 5", r, model[5]);
    bus_read(12'h1FC, r); check(r == model[127], "R2 buffer word 127", r, model[127]);
    // R12: low address bits ignored
    model[9] = 32'hDEAD_0009;
    bus_write(12'h027, model[9]);
    bus_read(12'h025, r); check(r == model[9], "R12 low byte bits ignored on buffer", r, model[9]);
    bus_write(12'h803, 32'h0000_0024);
    bus_read(12'h802, r); check(r == 32'h24, "R12 low byte bits ignored on register", r, 32'h24);

    // R3: register read/write
    bus_write(12'h804, 32'd77);
    bus_read(12'h804, r); check(r == 32'd77, "R3 start word readback", r, 32'd77);
    bus_read(12'h808, r); check(r == 32'h0, "R3 direction reads 0", r, 32'h0);

    // R4 / R7: configuration at full rate
    w0 = wr_seen;
    run_config(3, 8);
    bus_read(12'h80C, r); check(r[0] == 1'b0, "R7 done clears after launch", r, 32'h3E);
    wait_done();
    check(wr_seen - w0 == 8, "R4 word count full rate", 32'(wr_seen - w0), 32'd8);
    check(exp_q.size() == 0, "R4 all expected words sent", 32'(exp_q.size()), 32'd0);

    // R4 / R6: configuration with random busy
    busy_rand = 1'b1;
    w0 = wr_seen;
    run_config(100, 20);
    wait_done();
    check(wr_seen - w0 == 20, "R6 word count under busy", 32'(wr_seen - w0), 32'd20);
    check(exp_q.size() == 0, "R6 no word lost under busy", 32'(exp_q.size()), 32'd0);

    // R5: readback with random busy, then check the buffer
    b0 = rb_idx;
    bus_write(12'h800, 32'd40);
    bus_write(12'h804, 32'd200);
    bus_write(12'h808, 32'h1);
    wait_done();
    busy_rand = 1'b0;
    for (int i = 0; i < 10; i++) begin
      bus_read(12'(4 * (200 + i)), r);
      check(r == rb_pat(b0 + i), "R5 readback word in buffer", r, rb_pat(b0 + i));
    end
    check(exp_q.size() == 0, "R5 readback sends no port writes", 32'(exp_q.size()), 32'd0);

    // R10: zero length in both directions
    repeat (4) @(posedge clk);
    strays = 0; allow_port = 1'b0;
    bus_write(12'h800, 32'd0);
    bus_write(12'h808, 32'h0);
    bus_read(12'h80C, r); check(r[0] == 1'b1, "R10 done after zero-length configuration", r, 32'h3F);
    bus_write(12'h808, 32'h1);
    bus_read(12'h80C, r); check(r[0] == 1'b1, "R10 done after zero-length readback", r, 32'h3F);
    repeat (5) @(posedge clk);
    check(strays == 0, "R10 no port strobes", 32'(strays), 32'd0);
    allow_port = 1'b1;

    // R11: writes while running are ignored
    busy_force = 1'b1;
    w0 = wr_seen;
    run_config(0, 4);
    bus_write(12'h800, 32'h40);
    bus_write(12'h804, 32'd7);
    bus_write(12'h808, 32'h1);
    bus_read(12'h800, r); check(r == 32'd16, "R11 length held while running", r, 32'd16);
    bus_read(12'h804, r); check(r == 32'd0, "R11 start word held while running", r, 32'd0);
    busy_force = 1'b0;
    wait_done();
    check(wr_seen - w0 == 4, "R11 running move unchanged", 32'(wr_seen - w0), 32'd4);
    check(exp_q.size() == 0, "R11 configuration direction kept", 32'(exp_q.size()), 32'd0);

    // R9: abort by status write
    busy_force = 1'b1;
    bus_write(12'h800, 32'd24);
    bus_write(12'h804, 32'd50);
    bus_write(12'h808, 32'h1);
    bus_read(12'h80C, r); check(r[0] == 1'b0, "R9 move running before abort", r, 32'h3E);
    bus_write(12'h80C, 32'h0000_1234);
    bus_read(12'h80C, r); check(r[0] == 1'b1, "R9 done after abort", r, 32'h3F);
    strays = 0; allow_port = 1'b0;
    busy_force = 1'b0;
    repeat (20) @(posedge clk);
    check(strays == 0, "R9 no port strobes after abort", 32'(strays), 32'd0);
    allow_port = 1'b1;

    // R8: port flags in the status word
    port_abort_n = 1'b0; port_rip = 1'b1; port_dalign = 1'b1; port_cfgerr = 1'b1;
    bus_read(12'h80C, r); check(r == 32'h1DF, "R8 status flags all toggled", r, 32'h1DF);
    port_rip = 1'b0; port_cfgerr = 1'b0;
    bus_read(12'h80C, r); check(r == 32'h09F, "R8 status flags mixed", r, 32'h09F);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule